// File: doc/BRIEF.md
# Alias-Aware Memory Access Filter

This block sits between the system fabric and a small on-chip word memory whose contents appear several times across a 16 KB address window. It decodes each fabric request down to the physical memory offset and applies the access policy to that offset, so every mirrored copy of a location gets the same treatment. A build-time switch chooses one of two policies. In alias-policy mode, the protected offset range is enforced in every mirror. In mirror-block mode, only the primary copy can be reached and every mirror address is refused for all callers.

Refused requests get an error response with zero data and never reach the storage array. The first refused request is recorded in a sticky violation record. Privileged software can read this record through a status address just above the window, and a privileged write to that address clears it. Addresses above the window that do not match the status address are not claimed, and they return a decode-miss error.

Top module: `aaf_filter`

## Requirements
- R1: An address with bits [15:14] equal to zero selects memory word addr[11:2]. The low two address bits are ignored. In alias-policy mode, a permitted access through any of the four mirrors (addr[13:12] = 0..3) reaches the same word.
- R2: In alias-policy mode, an unprivileged request (req_priv=0) whose offset addr[11:0] lies within [PROT_LO, PROT_HI] is refused, whichever mirror it arrives through. The four aliases of a protected location therefore all give the same result.
- R3: In mirror-block mode, every request with addr[13:12] not equal to zero is refused, privileged or not. Mirror 0 follows the R2 rule.
- R4: A refused request returns resp_err=1 and resp_rdata=0. A refused write leaves the memory word unchanged.
- R5: An address with bits [15:14] not equal to zero, other than the status address 0x4000, returns resp_err=1 and zero data. It changes no memory and no violation record.
- R6: req_ready is always 1. resp_valid is 1 in exactly the cycle after a cycle with req_valid=1, and 0 otherwise.
- R7: The first refused request sets viol_valid=1 and captures its full address in viol_addr and its privilege in viol_priv. Later refusals leave the record unchanged until it is cleared.
- R8: A privileged write to 0x4000 clears the record (valid, priv and address all go to 0) with resp_err=0. A privileged read of 0x4000 returns {14'b0, viol_valid at bit 17, viol_priv at bit 16, viol_addr in bits [15:0]}. Any unprivileged access to 0x4000 is refused and recorded.
- R9: During and right after synchronous active-low reset, resp_valid=0 and viol_valid=0, viol_priv=0, viol_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_addr | input | 16 | Fabric byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 = privileged caller |
| resp_valid | output | 1 | Response present, one cycle after acceptance |
| resp_err | output | 1 | Request refused or not claimed |
| resp_rdata | output | 32 | Read data, zero on error |
| viol_valid | output | 1 | Sticky violation recorded |
| viol_addr | output | 16 | Address of first refused request |
| viol_priv | output | 1 | Privilege of first refused request |

## Verification
The assertions assume that reset is held for at least one clock before traffic starts. They also assume that req_valid and the request fields stay stable between clock edges, because the block samples requests only at the edge. They further assume that memory words are written before they are read for data, since the array has no reset. The bench drives all inputs on the falling edge and removes requests while reset is active. It compares read data only for words it has already written, and it still checks the error flag and the zero-data rule on every refused read.

// File: rtl/aaf_pkg.sv
package aaf_pkg;

    // Outcome of the policy decision for one request.
    typedef enum logic [1:0] {
        ACC_MEM  = 2'd0,   // permitted memory access
        ACC_STAT = 2'd1,   // privileged status access
        ACC_DENY = 2'd2,   // refused by policy
        ACC_MISS = 2'd3    // address not claimed
    } acc_kind_e;

endpackage

// File: rtl/aaf_decode.sv
module aaf_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned OFFS_W    = 12,
    parameter int unsigned MIRROR_W  = 2,
    parameter int unsigned STAT_ADDR = 32'h4000
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                in_win,
    output logic                is_stat,
    output logic [MIRROR_W-1:0] mirror_idx,
    output logic [OFFS_W-1:0]   offset
);
    localparam int unsigned WIN_W = OFFS_W + MIRROR_W;
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    // Upper bits are dropped: every mirror folds onto the same offset.
    assign offset     = addr[OFFS_W-1:0];
    assign mirror_idx = addr[WIN_W-1:OFFS_W];

    generate
        if (WIN_W < ADDR_W) begin : g_upper
            assign in_win = (addr[ADDR_W-1:WIN_W] == '0);
        end else begin : g_full
            assign in_win = 1'b1;
        end
    endgenerate

    assign is_stat = !in_win && (addr == STAT_A);

endmodule

// File: rtl/aaf_policy.sv
module aaf_policy
    import aaf_pkg::*;
#(
    parameter int unsigned OFFS_W       = 12,
    parameter int unsigned MIRROR_W     = 2,
    parameter int unsigned PROT_LO      = 0,
    parameter int unsigned PROT_HI      = 32'hFFF,
    parameter bit          MIRROR_BLOCK = 1'b0
) (
    input  logic                in_win,
    input  logic                is_stat,
    input  logic [MIRROR_W-1:0] mirror_idx,
    input  logic [OFFS_W-1:0]   offset,
    input  logic                priv,
    output acc_kind_e           kind
);
    localparam logic [OFFS_W-1:0] P_LO  = OFFS_W'(PROT_LO);
    localparam logic [OFFS_W-1:0] P_HI  = OFFS_W'(PROT_HI);
    localparam logic [OFFS_W-1:0] O_MAX = '1;

    logic lo_ok;
    logic hi_ok;
    logic mirror_deny;
    logic prot_hit;

    // Range bounds: skip comparisons that would be constant.
    generate
        if (PROT_LO == 0) begin : g_lo_any
            assign lo_ok = 1'b1;
        end else begin : g_lo_cmp
            assign lo_ok = (offset >= P_LO);
        end
        if (P_HI == O_MAX) begin : g_hi_any
            assign hi_ok = 1'b1;
        end else begin : g_hi_cmp
            assign hi_ok = (offset <= P_HI);
        end
        if (MIRROR_BLOCK) begin : g_mblk
            assign mirror_deny = (mirror_idx != '0);
        end else begin : g_malias
            assign mirror_deny = 1'b0;
        end
    endgenerate

    // Policy works on the decoded offset, never on the raw address.
    assign prot_hit = lo_ok && hi_ok;

    always_comb begin
        if (is_stat) begin
            kind = priv ? ACC_STAT : ACC_DENY;
        end else if (!in_win) begin
            kind = ACC_MISS;
        end else if (mirror_deny) begin
            kind = ACC_DENY;
        end else if (!priv && prot_hit) begin
            kind = ACC_DENY;
        end else begin
            kind = ACC_MEM;
        end
    end

endmodule

// File: rtl/aaf_store.sv
module aaf_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[idx];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/aaf_filter.sv
module aaf_filter
    import aaf_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned OFFS_W       = 12,
    parameter int unsigned MIRROR_W     = 2,
    parameter int unsigned PROT_LO      = 0,
    parameter int unsigned PROT_HI      = 32'hFFF,
    parameter bit          MIRROR_BLOCK = 1'b0,
    parameter int unsigned STAT_ADDR    = 32'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_priv,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              viol_valid,
    output logic [ADDR_W-1:0] viol_addr,
    output logic              viol_priv
);
    localparam int unsigned LANE_W = $clog2(DATA_W / 8);
    localparam int unsigned IDX_W  = OFFS_W - LANE_W;

    typedef struct packed {
        logic              rsp_vld;
        logic              rsp_err;
        logic              rsp_mem;
        logic [DATA_W-1:0] rsp_data;
        logic              viol_vld;
        logic              viol_prv;
        logic [ADDR_W-1:0] viol_adr;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic                in_win;
    logic                is_stat;
    logic [MIRROR_W-1:0] mirror_idx;
    logic [OFFS_W-1:0]   offset;
    acc_kind_e           kind;
    logic                mem_we;
    logic                mem_re;
    logic                clr_req;
    logic [DATA_W-1:0]   store_rdata;
    logic [DATA_W-1:0]   stat_word;

    aaf_decode #(
        .ADDR_W   (ADDR_W),
        .OFFS_W   (OFFS_W),
        .MIRROR_W (MIRROR_W),
        .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .addr      (req_addr),
        .in_win    (in_win),
        .is_stat   (is_stat),
        .mirror_idx(mirror_idx),
        .offset    (offset)
    );

    aaf_policy #(
        .OFFS_W      (OFFS_W),
        .MIRROR_W    (MIRROR_W),
        .PROT_LO     (PROT_LO),
        .PROT_HI     (PROT_HI),
        .MIRROR_BLOCK(MIRROR_BLOCK)
    ) u_policy (
        .in_win    (in_win),
        .is_stat   (is_stat),
        .mirror_idx(mirror_idx),
        .offset    (offset),
        .priv      (req_priv),
        .kind      (kind)
    );

    aaf_store #(
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk  (clk),
        .we   (mem_we),
        .re   (mem_re),
        .idx  (offset[OFFS_W-1:LANE_W]),
        .wdata(req_wdata),
        .rdata(store_rdata)
    );

    // Status word: address, then privilege, then valid.
    always_comb begin
        stat_word                = '0;
        stat_word[ADDR_W-1:0]    = st_q.viol_adr;
        stat_word[ADDR_W]        = st_q.viol_prv;
        stat_word[ADDR_W+1]      = st_q.viol_vld;
    end

    always_comb begin
        st_d          = st_q;
        st_d.rsp_vld  = 1'b0;
        st_d.rsp_err  = 1'b0;
        st_d.rsp_mem  = 1'b0;
        st_d.rsp_data = '0;
        mem_we        = 1'b0;
        mem_re        = 1'b0;
        clr_req       = 1'b0;
        if (req_valid) begin
            st_d.rsp_vld = 1'b1;
            unique case (kind)
                ACC_MEM: begin
                    if (req_write) begin
                        mem_we = 1'b1;
                    end else begin
                        mem_re       = 1'b1;
                        st_d.rsp_mem = 1'b1;
                    end
                end
                ACC_STAT: begin
                    if (req_write) begin
                        clr_req       = 1'b1;
                        st_d.viol_vld = 1'b0;
                        st_d.viol_prv = 1'b0;
                        st_d.viol_adr = '0;
                    end else begin
                        st_d.rsp_data = stat_word;
                    end
                end
                ACC_DENY: begin
                    st_d.rsp_err = 1'b1;
                    if (!st_q.viol_vld) begin
                        st_d.viol_vld = 1'b1;
                        st_d.viol_prv = req_priv;
                        st_d.viol_adr = req_addr;
                    end
                end
                default: begin
                    st_d.rsp_err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = 1'b1;
    assign resp_valid = st_q.rsp_vld;
    assign resp_err   = st_q.rsp_err;
    assign resp_rdata = st_q.rsp_mem ? store_rdata : st_q.rsp_data;
    assign viol_valid = st_q.viol_vld;
    assign viol_addr  = st_q.viol_adr;
    assign viol_priv  = st_q.viol_prv;

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (resp_valid == $past(req_valid && req_ready)));  // R6
    AST_DENY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> !$past(mem_we));  // R4
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (resp_rdata == '0));  // R4
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(viol_valid) && !$past(clr_req)) |->
            (viol_valid && $stable(viol_addr) && $stable(viol_priv)));  // R7
    AST_MISS_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_MISS) |=> ($stable(viol_valid) && $stable(viol_addr)));  // R5

    generate
        if (MIRROR_BLOCK) begin : g_ast_mblk
            AST_MIRROR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && in_win && mirror_idx != '0) |=> (resp_valid && resp_err));  // R3
        end
    endgenerate

endmodule

// File: tb/test_aaf_filter.sv
module test_aaf_filter;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_priv = 1'b0;
    bit          done = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    logic        rdy0, rv0, re0, vv0, vp0, rdy1, rv1, re1, vv1, vp1;
    logic [31:0] rd0, rd1;
    logic [15:0] va0, va1;

    // Alias-policy instance with a narrower protected range.
    aaf_filter #(.PROT_HI(32'h7FF), .MIRROR_BLOCK(1'b0)) i_aaf_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_priv(req_priv), .resp_valid(rv0), .resp_err(re0), .resp_rdata(rd0),
        .viol_valid(vv0), .viol_addr(va0), .viol_priv(vp0));

    // Mirror-block instance with default protected range.
    aaf_filter #(.MIRROR_BLOCK(1'b1)) i_aaf_filter_blk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_priv(req_priv), .resp_valid(rv1), .resp_err(re1), .resp_rdata(rd1),
        .viol_valid(vv1), .viol_addr(va1), .viol_priv(vp1));

    logic        o_rdy [2];
    logic        o_rv  [2];
    logic        o_re  [2];
    logic [31:0] o_rd  [2];
    logic        o_vv  [2];
    logic [15:0] o_va  [2];
    logic        o_vp  [2];
    assign o_rdy[0] = rdy0; assign o_rdy[1] = rdy1;
    assign o_rv[0]  = rv0;  assign o_rv[1]  = rv1;
    assign o_re[0]  = re0;  assign o_re[1]  = re1;
    assign o_rd[0]  = rd0;  assign o_rd[1]  = rd1;
    assign o_vv[0]  = vv0;  assign o_vv[1]  = vv1;
    assign o_va[0]  = va0;  assign o_va[1]  = va1;
    assign o_vp[0]  = vp0;  assign o_vp[1]  = vp1;

    // Reference model state.
    int          plo [2] = '{0, 0};
    int          phi [2] = '{32'h7FF, 32'hFFF};
    logic [31:0] mm [int];
    bit          sv [2];
    logic [15:0] sa [2];
    bit          sp [2];
    bit          ev [2];
    bit          ee [2];
    bit          ek [2];
    logic [31:0] ed [2];
    string       et [2];
    string       st [2];

    // 0 memory, 1 status, 2 refused, 3 miss
    function automatic int kind_of(int d, logic [15:0] a, bit p);
        int off;
        off = int'(a[11:0]);
        if (a == 16'h4000) return p ? 1 : 2;
        if (a[15:14] != 2'b00) return 3;
        if (d == 1 && a[13:12] != 2'b00) return 2;
        if (!p && off >= plo[d] && off <= phi[d]) return 2;
        return 0;
    endfunction

    task automatic chk(int d, bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s dut%0d %s: actual %h expected %h", tag, d, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                ev[d] = 1'b0; sv[d] = 1'b0; sa[d] = '0; sp[d] = 1'b0;
                et[d] = "R9"; st[d] = "R9";
            end else if (req_valid) begin
                int k;
                int key;
                k = kind_of(d, req_addr, req_priv);
                key = d * 4096 + int'(req_addr[11:2]);
                ev[d] = 1'b1; ee[d] = (k >= 2); ed[d] = '0; ek[d] = 1'b1;
                st[d] = "R7";
                case (k)
                    0: begin
                        et[d] = "R1";
                        if (req_write) mm[key] = req_wdata;
                        else if (mm.exists(key)) ed[d] = mm[key];
                        else ek[d] = 1'b0;
                    end
                    1: begin
                        et[d] = "R8"; st[d] = "R8";
                        if (req_write) begin
                            sv[d] = 1'b0; sa[d] = '0; sp[d] = 1'b0;
                        end else begin
                            ed[d] = {14'b0, sv[d], sp[d], sa[d]};
                        end
                    end
                    2: begin
                        et[d] = (d == 1 && req_addr[13:12] != 2'b00) ? "R3" : "R2";
                        if (!sv[d]) begin
                            sv[d] = 1'b1; sa[d] = req_addr; sp[d] = req_priv;
                        end
                    end
                    default: et[d] = "R5";
                endcase
            end else begin
                ev[d] = 1'b0;
                st[d] = "R7";
            end
        end
        #(CLK_P/4);
        if (!done) begin
            for (int d = 0; d < 2; d++) begin
                chk(d, o_rdy[d] === 1'b1, "R6", "req_ready", 32'(o_rdy[d]), 32'd1);
                chk(d, o_rv[d] === ev[d], (rst_n ? "R6" : "R9"), "resp_valid",
                    32'(o_rv[d]), 32'(ev[d]));
                if (ev[d]) begin
                    chk(d, o_re[d] === ee[d], et[d], "resp_err", 32'(o_re[d]), 32'(ee[d]));
                    if (ee[d])
                        chk(d, o_rd[d] === 32'h0, "R4", "refused rdata", o_rd[d], 32'h0);
                    else if (ek[d])
                        chk(d, o_rd[d] === ed[d], et[d], "rdata", o_rd[d], ed[d]);
                end
                chk(d, o_vv[d] === sv[d], st[d], "viol_valid", 32'(o_vv[d]), 32'(sv[d]));
                chk(d, o_va[d] === sa[d], st[d], "viol_addr", 32'(o_va[d]), 32'(sa[d]));
                chk(d, o_vp[d] === sp[d], st[d], "viol_priv", 32'(o_vp[d]), 32'(sp[d]));
            end
        end
    end

    task automatic issue(logic [15:0] a, bit w, logic [31:0] dat, bit p);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = dat; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);   // R9 reset state checked by monitor
        rst_n = 1'b1;
        idle(1);
        // R1: privileged write in primary, read through every mirror
        issue(16'h0010, 1'b1, 32'hA5A5_0001, 1'b1);
        issue(16'h0010, 1'b0, '0, 1'b1);
        issue(16'h1010, 1'b0, '0, 1'b1);  // R3 first refusal on blocking instance
        issue(16'h2010, 1'b0, '0, 1'b1);
        issue(16'h3010, 1'b0, '0, 1'b1);
        // R2: unprivileged read of all four aliases gives the same refusal
        issue(16'h0010, 1'b0, '0, 1'b0);
        issue(16'h1010, 1'b0, '0, 1'b0);
        issue(16'h2010, 1'b0, '0, 1'b0);
        issue(16'h3010, 1'b0, '0, 1'b0);
        // R4: refused write through a mirror, then privileged readback
        issue(16'h2010, 1'b1, 32'hDEAD_BEEF, 1'b0);
        issue(16'h0010, 1'b0, '0, 1'b1);
        idle(2);
        // Unprotected offset on the alias instance
        issue(16'h0900, 1'b1, 32'h1234_5678, 1'b0);
        issue(16'h3900, 1'b0, '0, 1'b0);
        issue(16'h1900, 1'b1, 32'h0BAD_F00D, 1'b1);
        issue(16'h0900, 1'b0, '0, 1'b0);
        issue(16'h0900, 1'b0, '0, 1'b1);
        // R1: low address bits ignored
        issue(16'h0023, 1'b1, 32'h0000_C0DE, 1'b1);
        issue(16'h0020, 1'b0, '0, 1'b1);
        // R5: unclaimed addresses
        issue(16'h4004, 1'b0, '0, 1'b1);
        issue(16'h8000, 1'b1, 32'hFFFF_FFFF, 1'b1);
        issue(16'hFFFC, 1'b0, '0, 1'b0);
        issue(16'h0020, 1'b0, '0, 1'b1);
        // R8: status read, refused unprivileged clear, privileged clear
        issue(16'h4000, 1'b0, '0, 1'b1);
        issue(16'h4000, 1'b1, '0, 1'b0);
        issue(16'h4000, 1'b1, '0, 1'b1);
        issue(16'h4000, 1'b0, '0, 1'b1);
        // R7: new first refusal after clear, second does not overwrite
        issue(16'h3004, 1'b1, 32'h5555_0000, 1'b0);
        issue(16'h2008, 1'b0, '0, 1'b1);
        issue(16'h4000, 1'b0, '0, 1'b1);
        issue(16'h4000, 1'b1, '0, 1'b1);
        idle(1);
        // Mixed stream with gaps
        for (int i = 0; i < 64; i++) begin
            logic [15:0] a;
            a = 16'(i * 32'h0B44) ^ 16'(i << 12);
            issue(a, i[1], 32'(i) * 32'h0101_0101, i[0]);
            if (i % 5 == 0) idle(1);
        end
        idle(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule